// File: doc/BRIEF.md
# Scaler Phase Parameter Calculator

This block works out the setup values a video scaling engine needs for one plane. After a start pulse it samples the plane's source size, the destination size, a rotation flag and a mask of the planes that ask for scaling. Source width and height arrive as unsigned 16.16 fixed-point values. Destination width and height are plain integers.

For the selected plane it returns four results: the upscale factor on each axis as a 16.16 value, the initial phase and phase step on each axis, and an enable for an enhancement filter. The filter is enabled when the upscale on either axis is at least two.

All quotients come from one restoring divider. The divider takes a 64-bit dividend and produces one quotient bit per clock. The six divisions run one after another. Invalid requests end the run early with an error flag set and all results cleared. A request is invalid when more than one plane asks for scaling or when a divisor would be zero. A request in which no plane asks for scaling ends at once with scaling disabled.

Top module: `scaler_phase_calc`

## Requirements
- R1: If the sampled mask has more than one bit set (mask AND (mask − 1) nonzero), the run ends with `err`=1, `scaleEn`=0, `enhEn`=0 and all six numeric results zero.
- R2: If the sampled mask is zero, the run ends with `err`=0, `scaleEn`=0, `enhEn`=0 and all six numeric results zero. No division is performed.
- R3: On a valid run, `hUpFactor` = low 32 bits of (outWidth · 2^32) / srcWidth, and `vUpFactor` is the same on the vertical axis (integer division), giving a 16.16 value.
- R4: On a valid run, `enhEn`=1 exactly when bits [31:16] of either upscale factor are ≥ 2.
- R5: With `rotate`=1, the horizontal input size is srcHeight[31:16] and the vertical input size is srcWidth[31:16]. With `rotate`=0, width maps to horizontal and height to vertical.
- R6: On each axis, initial phase = ((input · 16) / output + 1) / 2, with integer division at both steps.
- R7: On each axis, phase step = low 32 bits of (input · 65536) / output.
- R8: If the mask holds exactly one bit and any of srcWidth, srcHeight, outWidth or outHeight is zero, the run ends with `err`=1, `scaleEn`=0 and all numeric results zero.
- R9: Each accepted start produces exactly one single-cycle `done` pulse. Results are valid in that same cycle. A start that arrives while a run is in progress is ignored. Inputs are sampled only in the cycle of an accepted start.
- R10: Every output except `done` keeps its value from a `done` pulse until the next start, whatever the data inputs do meanwhile.
- R11: After reset, every output is zero.
- R12: Each division returns the exact quotient: quotient · divisor + remainder equals the dividend, with the remainder less than the divisor.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Launches a calculation when idle |
| srcWidth | input | FIX_W | Source width, 16.16 |
| srcHeight | input | FIX_W | Source height, 16.16 |
| outWidth | input | OUT_W | Destination width, integer |
| outHeight | input | OUT_W | Destination height, integer |
| rotate | input | 1 | Swap source axes |
| scaleMask | input | MASK_W | Planes requesting scaling |
| done | output | 1 | One-cycle completion pulse |
| err | output | 1 | Request rejected |
| scaleEn | output | 1 | Scaling active for the request |
| enhEn | output | 1 | Enhancement filter enable |
| hUpFactor | output | PH_W | Horizontal upscale, 16.16 |
| vUpFactor | output | PH_W | Vertical upscale, 16.16 |
| hInitPhase | output | PH_W | Horizontal initial phase |
| hDeltaPhase | output | PH_W | Horizontal phase step |
| vInitPhase | output | PH_W | Vertical initial phase |
| vDeltaPhase | output | PH_W | Vertical phase step |

## Verification
The bench builds the block with its default parameters: 32-bit 16.16 source sizes, 16-bit destination sizes, an 8-plane mask and a 64-bit divider. These widths allow full-HD sizes, fractional source sizes, an upscale of exactly 2.0 against one just below it, and a request from the mask's top bit. Directed cases cover the rotated and unrotated mappings, the two error paths and the empty mask. They also cover a start issued in the middle of a run and inputs that change after `done`.

// File: rtl/spc_pkg.sv
package spc_pkg;
  localparam int PHASE_BITS  = 4;
  localparam int PHASE_SHIFT = 12;

  typedef enum logic [2:0] {
    OP_HUP    = 3'd0,
    OP_VUP    = 3'd1,
    OP_HINIT  = 3'd2,
    OP_HDELTA = 3'd3,
    OP_VINIT  = 3'd4,
    OP_VDELTA = 3'd5
  } spcOp_e;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_CHECK,
    ST_ISSUE,
    ST_WAIT,
    ST_FIN
  } spcState_e;

  typedef struct packed {
    logic   capture;
    logic   divGo;
    logic   store;
    spcOp_e op;
    logic   finOk;
    logic   finOff;
    logic   finErr;
  } spcStrobe_t;
endpackage

// File: rtl/spc_divider.sv
module spc_divider #(
  parameter int W = 64
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic         go,
  input  logic [W-1:0] dividend,
  input  logic [W-1:0] divisor,
  output logic         fin,
  output logic [W-1:0] quo,
  output logic [W-1:0] rem
);
  localparam int CNT_W = $clog2(W + 1);

  logic [W:0]       remR;
  logic [W-1:0]     quoR;
  logic [W-1:0]     dvsR;
  logic [CNT_W-1:0] cnt;
  logic             active;
  logic [W:0]       trial;
  logic             fits;

  assign trial = {remR[W-1:0], quoR[W-1]};
  assign fits  = trial >= {1'b0, dvsR};

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      remR   <= '0;
      quoR   <= '0;
      dvsR   <= '0;
      cnt    <= '0;
      active <= 1'b0;
      fin    <= 1'b0;
    end else begin
      fin <= 1'b0;
      if (go && !active) begin
        remR   <= '0;
        quoR   <= dividend;
        dvsR   <= divisor;
        cnt    <= CNT_W'(W);
        active <= 1'b1;
      end else if (active) begin
        remR <= fits ? (trial - {1'b0, dvsR}) : trial;
        quoR <= {quoR[W-2:0], fits};
        cnt  <= cnt - 1'b1;
        if (cnt == CNT_W'(1)) begin
          active <= 1'b0;
          fin    <= 1'b1;
        end
      end
    end
  end

  assign quo = quoR;
  assign rem = remR[W-1:0];
endmodule

// File: rtl/spc_ctrl.sv
module spc_ctrl
  import spc_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       start,
  input  logic       maskZero,
  input  logic       maskMulti,
  input  logic       zeroDiv,
  input  logic       divFin,
  output spcStrobe_t strb
);
  spcState_e state, stateNxt;
  spcOp_e    opR, opNxt;

  always_comb begin
    stateNxt = state;
    opNxt    = opR;
    strb     = '0;
    strb.op  = opR;
    unique case (state)
      ST_IDLE: begin
        if (start) begin
          strb.capture = 1'b1;
          stateNxt     = ST_CHECK;
        end
      end
      ST_CHECK: begin
        if (maskZero) begin
          strb.finOff = 1'b1;
          stateNxt    = ST_IDLE;
        end else if (maskMulti || zeroDiv) begin
          strb.finErr = 1'b1;
          stateNxt    = ST_IDLE;
        end else begin
          opNxt    = OP_HUP;
          stateNxt = ST_ISSUE;
        end
      end
      ST_ISSUE: begin
        strb.divGo = 1'b1;
        stateNxt   = ST_WAIT;
      end
      ST_WAIT: begin
        if (divFin) begin
          strb.store = 1'b1;
          if (opR == OP_VDELTA) begin
            stateNxt = ST_FIN;
          end else begin
            opNxt    = spcOp_e'(opR + 3'd1);
            stateNxt = ST_ISSUE;
          end
        end
      end
      ST_FIN: begin
        strb.finOk = 1'b1;
        stateNxt   = ST_IDLE;
      end
      default: stateNxt = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state <= ST_IDLE;
      opR   <= OP_HUP;
    end else begin
      state <= stateNxt;
      opR   <= opNxt;
    end
  end
endmodule

// File: rtl/spc_datapath.sv
module spc_datapath
  import spc_pkg::*;
#(
  parameter int FIX_W  = 32,
  parameter int OUT_W  = 16,
  parameter int MASK_W = 8,
  parameter int PH_W   = 32,
  parameter int DIV_W  = 64
) (
  input  logic              clk,
  input  logic              rstN,
  input  spcStrobe_t        strb,
  input  logic [FIX_W-1:0]  srcWidth,
  input  logic [FIX_W-1:0]  srcHeight,
  input  logic [OUT_W-1:0]  outWidth,
  input  logic [OUT_W-1:0]  outHeight,
  input  logic              rotate,
  input  logic [MASK_W-1:0] scaleMask,
  input  logic [PH_W:0]     quoLo,
  output logic              maskZero,
  output logic              maskMulti,
  output logic              zeroDiv,
  output logic [MASK_W-1:0] capMask,
  output logic [DIV_W-1:0]  dvd,
  output logic [DIV_W-1:0]  dvs,
  output logic              done,
  output logic              err,
  output logic              scaleEn,
  output logic              enhEn,
  output logic [PH_W-1:0]   hUpFactor,
  output logic [PH_W-1:0]   vUpFactor,
  output logic [PH_W-1:0]   hInitPhase,
  output logic [PH_W-1:0]   hDeltaPhase,
  output logic [PH_W-1:0]   vInitPhase,
  output logic [PH_W-1:0]   vDeltaPhase
);
  localparam int FRAC  = FIX_W / 2;
  localparam int INT_W = FIX_W - FRAC;
  localparam int UP_SH = 2 * FRAC;
  localparam int DL_SH = PHASE_BITS + PHASE_SHIFT;

  logic [FIX_W-1:0] capSrcW, capSrcH;
  logic [OUT_W-1:0] capOutW, capOutH;
  logic             capRot;
  logic [INT_W-1:0] inW, inH;
  logic [PH_W:0]    roundSum;
  logic [PH_W-1:0]  halfStep;
  logic             enhNow;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      capSrcW <= '0;
      capSrcH <= '0;
      capOutW <= '0;
      capOutH <= '0;
      capRot  <= 1'b0;
      capMask <= '0;
    end else if (strb.capture) begin
      capSrcW <= srcWidth;
      capSrcH <= srcHeight;
      capOutW <= outWidth;
      capOutH <= outHeight;
      capRot  <= rotate;
      capMask <= scaleMask;
    end
  end

  assign inW       = capRot ? capSrcH[FIX_W-1:FRAC] : capSrcW[FIX_W-1:FRAC];
  assign inH       = capRot ? capSrcW[FIX_W-1:FRAC] : capSrcH[FIX_W-1:FRAC];
  assign maskZero  = capMask == '0;
  assign maskMulti = (capMask & (capMask - MASK_W'(1))) != '0;
  assign zeroDiv   = (capSrcW == '0) || (capSrcH == '0) ||
                     (capOutW == '0) || (capOutH == '0);

  always_comb begin
    dvd = '0;
    dvs = '0;
    unique case (strb.op)
      OP_HUP:    begin dvd = DIV_W'(capOutW) << UP_SH;      dvs = DIV_W'(capSrcW); end
      OP_VUP:    begin dvd = DIV_W'(capOutH) << UP_SH;      dvs = DIV_W'(capSrcH); end
      OP_HINIT:  begin dvd = DIV_W'(inW) << PHASE_BITS;     dvs = DIV_W'(capOutW); end
      OP_HDELTA: begin dvd = DIV_W'(inW) << DL_SH;          dvs = DIV_W'(capOutW); end
      OP_VINIT:  begin dvd = DIV_W'(inH) << PHASE_BITS;     dvs = DIV_W'(capOutH); end
      OP_VDELTA: begin dvd = DIV_W'(inH) << DL_SH;          dvs = DIV_W'(capOutH); end
      default:   begin dvd = '0;                            dvs = '0;              end
    endcase
  end

  assign roundSum = quoLo + (PH_W+1)'(1);
  assign halfStep = roundSum[PH_W:1];
  assign enhNow   = (hUpFactor[PH_W-1:FRAC] >= (PH_W-FRAC)'(2)) ||
                    (vUpFactor[PH_W-1:FRAC] >= (PH_W-FRAC)'(2));

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      done        <= 1'b0;
      err         <= 1'b0;
      scaleEn     <= 1'b0;
      enhEn       <= 1'b0;
      hUpFactor   <= '0;
      vUpFactor   <= '0;
      hInitPhase  <= '0;
      hDeltaPhase <= '0;
      vInitPhase  <= '0;
      vDeltaPhase <= '0;
    end else begin
      done <= strb.finOk | strb.finOff | strb.finErr;
      if (strb.store) begin
        unique case (strb.op)
          OP_HUP:    hUpFactor   <= quoLo[PH_W-1:0];
          OP_VUP:    vUpFactor   <= quoLo[PH_W-1:0];
          OP_HINIT:  hInitPhase  <= halfStep;
          OP_HDELTA: hDeltaPhase <= quoLo[PH_W-1:0];
          OP_VINIT:  vInitPhase  <= halfStep;
          OP_VDELTA: vDeltaPhase <= quoLo[PH_W-1:0];
          default:   ;
        endcase
      end
      if (strb.finOk) begin
        err     <= 1'b0;
        scaleEn <= 1'b1;
        enhEn   <= enhNow;
      end else if (strb.finOff || strb.finErr) begin
        err         <= strb.finErr;
        scaleEn     <= 1'b0;
        enhEn       <= 1'b0;
        hUpFactor   <= '0;
        vUpFactor   <= '0;
        hInitPhase  <= '0;
        hDeltaPhase <= '0;
        vInitPhase  <= '0;
        vDeltaPhase <= '0;
      end
    end
  end
endmodule

// File: rtl/scaler_phase_calc.sv
module scaler_phase_calc
  import spc_pkg::*;
#(
  parameter int FIX_W  = 32,
  parameter int OUT_W  = 16,
  parameter int MASK_W = 8,
  parameter int PH_W   = 32,
  parameter int DIV_W  = 64
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              start,
  input  logic [FIX_W-1:0]  srcWidth,
  input  logic [FIX_W-1:0]  srcHeight,
  input  logic [OUT_W-1:0]  outWidth,
  input  logic [OUT_W-1:0]  outHeight,
  input  logic              rotate,
  input  logic [MASK_W-1:0] scaleMask,
  output logic              done,
  output logic              err,
  output logic              scaleEn,
  output logic              enhEn,
  output logic [PH_W-1:0]   hUpFactor,
  output logic [PH_W-1:0]   vUpFactor,
  output logic [PH_W-1:0]   hInitPhase,
  output logic [PH_W-1:0]   hDeltaPhase,
  output logic [PH_W-1:0]   vInitPhase,
  output logic [PH_W-1:0]   vDeltaPhase
);
  spcStrobe_t        strb;
  logic              maskZero, maskMulti, zeroDiv, divFin;
  logic [MASK_W-1:0] capMask;
  logic [DIV_W-1:0]  dvd, dvs, quo, rem;

  spc_ctrl ctrl_i (
    .clk(clk), .rstN(rstN), .start(start),
    .maskZero(maskZero), .maskMulti(maskMulti), .zeroDiv(zeroDiv),
    .divFin(divFin), .strb(strb)
  );

  spc_divider #(.W(DIV_W)) div_i (
    .clk(clk), .rstN(rstN), .go(strb.divGo),
    .dividend(dvd), .divisor(dvs),
    .fin(divFin), .quo(quo), .rem(rem)
  );

  spc_datapath #(
    .FIX_W(FIX_W), .OUT_W(OUT_W), .MASK_W(MASK_W), .PH_W(PH_W), .DIV_W(DIV_W)
  ) dp_i (
    .clk(clk), .rstN(rstN), .strb(strb),
    .srcWidth(srcWidth), .srcHeight(srcHeight),
    .outWidth(outWidth), .outHeight(outHeight),
    .rotate(rotate), .scaleMask(scaleMask), .quoLo(quo[PH_W:0]),
    .maskZero(maskZero), .maskMulti(maskMulti), .zeroDiv(zeroDiv),
    .capMask(capMask), .dvd(dvd), .dvs(dvs),
    .done(done), .err(err), .scaleEn(scaleEn), .enhEn(enhEn),
    .hUpFactor(hUpFactor), .vUpFactor(vUpFactor),
    .hInitPhase(hInitPhase), .hDeltaPhase(hDeltaPhase),
    .vInitPhase(vInitPhase), .vDeltaPhase(vDeltaPhase)
  );
endmodule

// File: rtl/spc_checker.sv
module spc_checker #(
  parameter int MASK_W = 8,
  parameter int PH_W   = 32,
  parameter int DIV_W  = 64
) (
  input logic              clk,
  input logic              rstN,
  input logic              start,
  input logic              done,
  input logic              err,
  input logic              scaleEn,
  input logic              enhEn,
  input logic [PH_W-1:0]   hUpFactor,
  input logic [PH_W-1:0]   vUpFactor,
  input logic [PH_W-1:0]   hInitPhase,
  input logic [PH_W-1:0]   hDeltaPhase,
  input logic [PH_W-1:0]   vInitPhase,
  input logic [PH_W-1:0]   vDeltaPhase,
  input logic [MASK_W-1:0] capMask,
  input logic              divGo,
  input logic              divFin,
  input logic [DIV_W-1:0]  dvd,
  input logic [DIV_W-1:0]  dvs,
  input logic [DIV_W-1:0]  quo,
  input logic [DIV_W-1:0]  rem
);
  localparam int HALF = PH_W / 2;

  logic             settled;
  logic [DIV_W-1:0] dvdC, dvsC;
  logic [2*DIV_W-1:0] recon;
  logic [6*PH_W+3:0]  outVec;

  assign outVec = {err, scaleEn, enhEn, 1'b0, hUpFactor, vUpFactor,
                   hInitPhase, hDeltaPhase, vInitPhase, vDeltaPhase};
  assign recon  = ({{DIV_W{1'b0}}, quo} * {{DIV_W{1'b0}}, dvsC}) +
                  {{DIV_W{1'b0}}, rem};

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      settled <= 1'b0;
      dvdC    <= '0;
      dvsC    <= '0;
    end else begin
      if (start) settled <= 1'b0;
      else if (done) settled <= 1'b1;
      if (divGo) begin
        dvdC <= dvd;
        dvsC <= dvs;
      end
    end
  end

  // R9
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);

  // R1
  multi_mask_err_chk: assert property (@(posedge clk) disable iff (!rstN)
    (done && ((capMask & (capMask - MASK_W'(1))) != '0)) |-> (err && !scaleEn));

  // R2
  empty_mask_off_chk: assert property (@(posedge clk) disable iff (!rstN)
    (done && capMask == '0) |-> (!err && !scaleEn && !enhEn));

  // R8
  err_excl_chk: assert property (@(posedge clk) disable iff (!rstN)
    err |-> (!scaleEn && !enhEn));

  // R4
  enh_rule_chk: assert property (@(posedge clk) disable iff (!rstN)
    (done && scaleEn) |-> (enhEn == ((hUpFactor[PH_W-1:HALF] >= (PH_W-HALF)'(2)) ||
                                     (vUpFactor[PH_W-1:HALF] >= (PH_W-HALF)'(2)))));

  // R10
  hold_outputs_chk: assert property (@(posedge clk) disable iff (!rstN)
    (settled && !start) |=> $stable(outVec));

  // R12
  div_exact_chk: assert property (@(posedge clk) disable iff (!rstN)
    divFin |-> ((recon == {{DIV_W{1'b0}}, dvdC}) && (rem < dvsC)));
endmodule

bind scaler_phase_calc spc_checker #(
  .MASK_W(MASK_W), .PH_W(PH_W), .DIV_W(DIV_W)
) chk_i (
  .clk(clk), .rstN(rstN), .start(start), .done(done), .err(err),
  .scaleEn(scaleEn), .enhEn(enhEn),
  .hUpFactor(hUpFactor), .vUpFactor(vUpFactor),
  .hInitPhase(hInitPhase), .hDeltaPhase(hDeltaPhase),
  .vInitPhase(vInitPhase), .vDeltaPhase(vDeltaPhase),
  .capMask(capMask), .divGo(strb.divGo), .divFin(divFin),
  .dvd(dvd), .dvs(dvs), .quo(quo), .rem(rem)
);

// File: tb/scaler_phase_calc_tb.sv
module scaler_phase_calc_tb_top;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        start = 1'b0;
  logic [31:0] srcWidth = '0, srcHeight = '0;
  logic [15:0] outWidth = '0, outHeight = '0;
  logic        rotate = 1'b0;
  logic [7:0]  scaleMask = '0;
  logic        done, err, scaleEn, enhEn;
  logic [31:0] hUpFactor, vUpFactor, hInitPhase, hDeltaPhase, vInitPhase, vDeltaPhase;

  int tests = 0;
  int fails = 0;
  int cycles = 0;
  bit finished = 1'b0;

  always #10 clk = ~clk;

  scaler_phase_calc dut_i (
    .clk(clk), .rstN(rstN), .start(start),
    .srcWidth(srcWidth), .srcHeight(srcHeight),
    .outWidth(outWidth), .outHeight(outHeight),
    .rotate(rotate), .scaleMask(scaleMask),
    .done(done), .err(err), .scaleEn(scaleEn), .enhEn(enhEn),
    .hUpFactor(hUpFactor), .vUpFactor(vUpFactor),
    .hInitPhase(hInitPhase), .hDeltaPhase(hDeltaPhase),
    .vInitPhase(vInitPhase), .vDeltaPhase(vDeltaPhase)
  );

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (cycles > 150000 && !finished) begin
      finished = 1'b1;
      fails++;
      tests++;
      $display("FAIL R9 watchdog expired: actual=%0d cycles expected<=150000", cycles);
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual=0x%08h expected=0x%08h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] upFactor(input logic [15:0] o, input logic [31:0] s);
    logic [63:0] t;
    t = ({48'b0, o} << 32) / {32'b0, s};
    return t[31:0];
  endfunction

  function automatic logic [31:0] initPh(input logic [15:0] i, input logic [15:0] o);
    logic [63:0] t;
    t = ((({48'b0, i} << 4) / {48'b0, o}) + 64'd1) >> 1;
    return t[31:0];
  endfunction

  function automatic logic [31:0] deltaPh(input logic [15:0] i, input logic [15:0] o);
    logic [63:0] t;
    t = ({48'b0, i} << 16) / {48'b0, o};
    return t[31:0];
  endfunction

  task automatic pulseStart();
    @(negedge clk);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
  endtask

  task automatic waitDone(input string tag);
    for (int k = 0; k < 3000; k++) begin
      if (done) return;
      @(negedge clk);
    end
    tests++;
    fails++;
    $display("FAIL R9 %s: done actual=0 expected=1 within 3000 cycles", tag);
  endtask

  task automatic checkOutputs(input string tag, input logic [31:0] sw, input logic [31:0] sh,
                              input logic [15:0] ow, input logic [15:0] oh, input logic rot,
                              input logic [7:0] m);
    logic multi, zdiv, ok;
    logic [15:0] iw, ih;
    logic [31:0] eHu, eVu;
    multi = (m & (m - 8'd1)) != 0;
    zdiv  = (sw == 0) || (sh == 0) || (ow == 0) || (oh == 0);
    ok    = (m != 0) && !multi && !zdiv;
    iw = rot ? sh[31:16] : sw[31:16];
    ih = rot ? sw[31:16] : sh[31:16];
    eHu = ok ? upFactor(ow, sw) : 32'd0;
    eVu = ok ? upFactor(oh, sh) : 32'd0;
    check({"R1/R8 err ", tag}, {31'b0, err}, {31'b0, (m != 0) && (multi || zdiv)});
    check({"R2 scaleEn ", tag}, {31'b0, scaleEn}, {31'b0, ok});
    check({"R4 enhEn ", tag}, {31'b0, enhEn},
          {31'b0, ok && ((eHu[31:16] >= 16'd2) || (eVu[31:16] >= 16'd2))});
    check({"R3/R12 hUp ", tag}, hUpFactor, eHu);
    check({"R3/R12 vUp ", tag}, vUpFactor, eVu);
    check({"R5/R6 hInit ", tag}, hInitPhase, ok ? initPh(iw, ow) : 32'd0);
    check({"R5/R7 hDelta ", tag}, hDeltaPhase, ok ? deltaPh(iw, ow) : 32'd0);
    check({"R5/R6 vInit ", tag}, vInitPhase, ok ? initPh(ih, oh) : 32'd0);
    check({"R5/R7 vDelta ", tag}, vDeltaPhase, ok ? deltaPh(ih, oh) : 32'd0);
  endtask

  task automatic runCase(input string tag, input logic [31:0] sw, input logic [31:0] sh,
                         input logic [15:0] ow, input logic [15:0] oh, input logic rot,
                         input logic [7:0] m);
    @(negedge clk);
    srcWidth = sw; srcHeight = sh; outWidth = ow; outHeight = oh;
    rotate = rot; scaleMask = m;
    pulseStart();
    waitDone(tag);
    checkOutputs(tag, sw, sh, ow, oh, rot, m);
    @(negedge clk);
    check({"R9 done single pulse ", tag}, {31'b0, done}, 32'd0);
  endtask

  task automatic testReset();
    check("R11 reset done", {31'b0, done}, 32'd0);
    check("R11 reset flags", {29'b0, err, scaleEn, enhEn}, 32'd0);
    check("R11 reset hUp", hUpFactor, 32'd0);
    check("R11 reset vDelta", vDeltaPhase, 32'd0);
  endtask

  task automatic testHold();
    runCase("R10 base", 32'd1920 << 16, 32'd1080 << 16, 16'd1280, 16'd720, 1'b0, 8'h01);
    srcWidth = 32'd77 << 16; outWidth = 16'd3; scaleMask = 8'hFF; rotate = 1'b1;
    for (int k = 0; k < 40; k++) @(negedge clk);
    checkOutputs("R10 held", 32'd1920 << 16, 32'd1080 << 16, 16'd1280, 16'd720, 1'b0, 8'h01);
  endtask

  task automatic testBusyStart();
    int extra;
    @(negedge clk);
    srcWidth = 32'd640 << 16; srcHeight = 32'd480 << 16;
    outWidth = 16'd1600; outHeight = 16'd900; rotate = 1'b0; scaleMask = 8'h04;
    pulseStart();
    for (int k = 0; k < 10; k++) @(negedge clk);
    srcWidth = 32'd50 << 16; outWidth = 16'd7; scaleMask = 8'h00;
    pulseStart();
    waitDone("R9 busy");
    checkOutputs("R9 busy start ignored", 32'd640 << 16, 32'd480 << 16,
                 16'd1600, 16'd900, 1'b0, 8'h04);
    extra = 0;
    for (int k = 0; k < 600; k++) begin
      @(negedge clk);
      if (done) extra++;
    end
    check("R9 no second done", extra, 32'd0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    testReset();
    rstN = 1'b1;
    runCase("downscale", 32'd1920 << 16, 32'd1080 << 16, 16'd1280, 16'd720, 1'b0, 8'h01);
    runCase("upscale 3x", 32'd640 << 16, 32'd360 << 16, 16'd1920, 16'd1080, 1'b0, 8'h02);
    runCase("R5 rotate", 32'd1080 << 16, 32'd1920 << 16, 16'd1920, 16'd1080, 1'b1, 8'h04);
    runCase("R5 rotate asym", 32'd300 << 16, 32'd500 << 16, 16'd640, 16'd200, 1'b1, 8'h10);
    runCase("R4 exactly 2x", 32'd100 << 16, 32'd100 << 16, 16'd200, 16'd199, 1'b0, 8'h01);
    runCase("R4 below 2x", 32'd100 << 16, 32'd100 << 16, 16'd199, 16'd150, 1'b0, 8'h01);
    runCase("R2 empty mask", 32'd100 << 16, 32'd100 << 16, 16'd200, 16'd200, 1'b0, 8'h00);
    runCase("R1 two planes", 32'd100 << 16, 32'd100 << 16, 16'd200, 16'd200, 1'b0, 8'h06);
    runCase("R1 top bit single", 32'd720 << 16, 32'd576 << 16, 16'd1024, 16'd768, 1'b0, 8'h80);
    runCase("R8 zero out width", 32'd100 << 16, 32'd100 << 16, 16'd0, 16'd200, 1'b0, 8'h01);
    runCase("R8 zero src height", 32'd100 << 16, 32'd0, 16'd200, 16'd200, 1'b0, 8'h08);
    runCase("R6 fractional src", 32'h0064_8000, 32'h014D_4000, 16'd50, 16'd333, 1'b0, 8'h20);
    testHold();
    testBusyStart();
    if (!finished) begin
      finished = 1'b1;
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end
endmodule